// File: doc/BRIEF.md
# Three-Level PWM Command Decoder

This block turns a sampled voltage code from one PWM control pin into one of three commands for a power stage: drive high, drive low, or shut both switches off. The input is an unsigned code in millivolts, taken from an ADC or comparator bank outside the block. Two hysteresis pairs separate the high and low levels from a middle band. The middle band is a command in its own right, not an undefined level.

A sample that sits in the middle band does not change the command at once. The decoder counts consecutive middle-band samples and declares the shutdown command only after a programmable dwell. A brief pass through the band while slewing between levels is therefore ignored. A decoded high or low level ends the shutdown command on the very clock that samples it. A pin left open floats to mid-supply, so it ends up decoded as shutdown. Every change of command raises a one-cycle registered strobe.

Top module: `pwm3_decoder`

## Requirements
- R1: From shutdown, only a code >= HI_RISE_MV (default 3550) yields HIGH, and only a code <= LO_FALL_MV (default 1150) yields LOW. Any code in between keeps the shutdown command, for as long as it lasts.
- R2: Leaving shutdown takes effect on the first clock edge that samples the high or low level. There is no dwell.
- R3: Once HIGH, the command stays HIGH for every code >= HI_FALL_MV (default 3450), including 3450 itself.
- R4: Once LOW, the command stays LOW for every code <= LO_RISE_MV (default 1250), including 1250 itself.
- R5: From HIGH or LOW, shutdown is declared on the clock edge that samples the HOLD_CYCLES-th consecutive middle-band code. A shorter run leaves the command unchanged.
- R6: Any sample outside the middle band restarts the dwell count from zero.
- R7: A code at the opposite level moves HIGH to LOW, or LOW to HIGH, directly on the next edge, without passing through shutdown.
- R8: While rst_ni is low, and right after it is released, the command is shutdown and chg_o is 0.
- R9: chg_o is 1 for exactly the cycle in which state_o holds a value different from the one it held in the previous cycle, and 0 at all other times.
- R10: state_o is encoded as 2'b00 LOW, 2'b01 HIGH and 2'b10 shutdown. The value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | CODE_W | Pin voltage in millivolts, unsigned |
| state_o | output | 2 | Decoded command (00 low, 01 high, 10 shutdown) |
| chg_o | output | 1 | One-cycle strobe on every change of command |

## Verification
The bound checker checks these rules on every cycle:
- the legal encoding of the command;
- that the strobe matches a change of command;
- that a high or low code leaves shutdown at once;
- that HIGH and LOW each hold across their own hysteresis band;
- that every entry into shutdown follows exactly HOLD_CYCLES middle-band samples.

Only the bench's scenarios can show the other behaviours:
- the exact threshold codes;
- the way an out-of-band sample splits two short dwells, which would together exceed the limit;
- that an open pin at mid-supply never leaves shutdown;
- the total number of strobes over a long sequence of commands.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  typedef enum logic [1:0] {
    CMD_LOW  = 2'b00,
    CMD_HIGH = 2'b01,
    CMD_TRI  = 2'b10
  } pwm_cmd_e;
endpackage

// File: rtl/pwm3_zone_cls.sv
module pwm3_zone_cls
  import pwm3_pkg::*;
#(
  parameter int CODE_W     = 13,
  parameter int HI_RISE_MV = 3550,
  parameter int HI_FALL_MV = 3450,
  parameter int LO_FALL_MV = 1150,
  parameter int LO_RISE_MV = 1250
) (
  input  logic [CODE_W-1:0] code_i,
  input  pwm_cmd_e          cur_i,
  output logic              want_hi_o,
  output logic              want_lo_o,
  output logic              in_win_o
);
  localparam logic [CODE_W-1:0] HI_RISE_C = CODE_W'(HI_RISE_MV);
  localparam logic [CODE_W-1:0] HI_FALL_C = CODE_W'(HI_FALL_MV);
  localparam logic [CODE_W-1:0] LO_FALL_C = CODE_W'(LO_FALL_MV);
  localparam logic [CODE_W-1:0] LO_RISE_C = CODE_W'(LO_RISE_MV);

  logic above_rise, above_fall, below_fall, below_rise;

  assign above_rise = code_i >= HI_RISE_C;
  assign above_fall = code_i >= HI_FALL_C;
  assign below_fall = code_i <= LO_FALL_C;
  assign below_rise = code_i <= LO_RISE_C;

  // hysteresis: the threshold in use depends on the current command
  always_comb begin
    unique case (cur_i)
      CMD_HIGH: begin
        want_hi_o = above_fall;
        want_lo_o = below_fall;
      end
      CMD_LOW: begin
        want_hi_o = above_rise;
        want_lo_o = below_rise;
      end
      default: begin
        want_hi_o = above_rise;
        want_lo_o = below_fall;
      end
    endcase
  end

  assign in_win_o = !want_hi_o && !want_lo_o && (cur_i != CMD_TRI);
endmodule

// File: rtl/pwm3_dwell_tmr.sv
module pwm3_dwell_tmr #(
  parameter int HOLD_CYCLES = 160
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  output logic done_o
);
  generate
    if (HOLD_CYCLES <= 1) begin : g_direct
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign done_o = inc_i;
    end else begin : g_count
      localparam int CNT_W = $clog2(HOLD_CYCLES);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);
      logic [CNT_W-1:0] cnt_q;

      assign done_o = inc_i && (cnt_q == CNT_LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                cnt_q <= '0;
        else if (!inc_i || done_o)  cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/pwm3_cmd_reg.sv
module pwm3_cmd_reg
  import pwm3_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     want_hi_i,
  input  logic     want_lo_i,
  input  logic     dwell_done_i,
  output pwm_cmd_e cmd_o,
  output logic     chg_o
);
  pwm_cmd_e cmd_d;

  always_comb begin
    if (want_hi_i)         cmd_d = CMD_HIGH;
    else if (want_lo_i)    cmd_d = CMD_LOW;
    else if (dwell_done_i) cmd_d = CMD_TRI;
    else                   cmd_d = cmd_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o <= CMD_TRI;
      chg_o <= 1'b0;
    end else begin
      cmd_o <= cmd_d;
      chg_o <= (cmd_d != cmd_o);
    end
  end
endmodule

// File: rtl/pwm3_decoder.sv
module pwm3_decoder
  import pwm3_pkg::*;
#(
  parameter int CODE_W      = 13,
  parameter int HI_RISE_MV  = 3550,
  parameter int HI_FALL_MV  = 3450,
  parameter int LO_FALL_MV  = 1150,
  parameter int LO_RISE_MV  = 1250,
  parameter int HOLD_CYCLES = 160
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic [1:0]        state_o,
  output logic              chg_o
);
  pwm_cmd_e cmd_q;
  logic     want_hi, want_lo, in_win, dwell_done;

  pwm3_zone_cls #(
    .CODE_W    (CODE_W),
    .HI_RISE_MV(HI_RISE_MV),
    .HI_FALL_MV(HI_FALL_MV),
    .LO_FALL_MV(LO_FALL_MV),
    .LO_RISE_MV(LO_RISE_MV)
  ) u_cls (
    .code_i   (code_i),
    .cur_i    (cmd_q),
    .want_hi_o(want_hi),
    .want_lo_o(want_lo),
    .in_win_o (in_win)
  );

  pwm3_dwell_tmr #(.HOLD_CYCLES(HOLD_CYCLES)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (in_win),
    .done_o(dwell_done)
  );

  pwm3_cmd_reg u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .want_hi_i   (want_hi),
    .want_lo_i   (want_lo),
    .dwell_done_i(dwell_done),
    .cmd_o       (cmd_q),
    .chg_o       (chg_o)
  );

  assign state_o = cmd_q;
endmodule

// File: rtl/pwm3_decoder_chk.sv
module pwm3_decoder_chk #(
  parameter int CODE_W      = 13,
  parameter int HI_RISE_MV  = 3550,
  parameter int HI_FALL_MV  = 3450,
  parameter int LO_FALL_MV  = 1150,
  parameter int LO_RISE_MV  = 1250,
  parameter int HOLD_CYCLES = 160
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] code_i,
  input logic [1:0]        state_o,
  input logic              chg_o
);
  localparam logic [1:0] S_LO = 2'b00;
  localparam logic [1:0] S_HI = 2'b01;
  localparam logic [1:0] S_TR = 2'b10;
  localparam int RUN_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(HOLD_CYCLES);

  logic             mid_hi, mid_lo, mid;
  logic [RUN_W-1:0] run_q;

  assign mid_hi = (state_o == S_HI) && (code_i < CODE_W'(HI_FALL_MV)) && (code_i > CODE_W'(LO_FALL_MV));
  assign mid_lo = (state_o == S_LO) && (code_i > CODE_W'(LO_RISE_MV)) && (code_i < CODE_W'(HI_RISE_MV));
  assign mid    = mid_hi || mid_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               run_q <= '0;
    else if (!mid)             run_q <= '0;
    else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
  end

  // R10
  enc_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) state_o != 2'b11);

  // R9
  strobe_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o == (state_o != $past(state_o)));

  // R2
  tri_exit_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_TR && code_i >= CODE_W'(HI_RISE_MV)) |=> state_o == S_HI);

  // R2
  tri_exit_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_TR && code_i <= CODE_W'(LO_FALL_MV)) |=> state_o == S_LO);

  // R3
  hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_HI && code_i >= CODE_W'(HI_FALL_MV)) |=> state_o == S_HI);

  // R4
  lo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_LO && code_i <= CODE_W'(LO_RISE_MV)) |=> state_o == S_LO);

  // R7
  lo_to_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_LO && code_i >= CODE_W'(HI_RISE_MV)) |=> state_o == S_HI);

  // R5
  dwell_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_TR && $past(state_o) != S_TR) |-> run_q == RUN_MAX);
endmodule

bind pwm3_decoder pwm3_decoder_chk #(
  .CODE_W     (CODE_W),
  .HI_RISE_MV (HI_RISE_MV),
  .HI_FALL_MV (HI_FALL_MV),
  .LO_FALL_MV (LO_FALL_MV),
  .LO_RISE_MV (LO_RISE_MV),
  .HOLD_CYCLES(HOLD_CYCLES)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .code_i (code_i),
  .state_o(state_o),
  .chg_o  (chg_o)
);

// File: tb/pwm3_decoder_test.sv
`timescale 1ns/1ps
module pwm3_decoder_test;
  localparam int CW   = 13;
  localparam int HOLD = 8;
  localparam int NV   = 18;

  localparam int VCODE [NV] = '{4000, 3500, 3400, 3600, 3400, 3400, 2500, 1000, 1200,
                                1300, 1300, 3500, 3550, 3450,  500, 3560, 1150, 1250};
  localparam int VCYC  [NV] = '{1, 20, 7, 1, 7, 1, 30, 1, 20, 7, 1, 3, 1, 10, 1, 1, 1, 10};
  localparam int VEXP  [NV] = '{1, 1, 1, 1, 1, 2, 2, 0, 0, 0, 2, 2, 1, 1, 0, 1, 0, 0};
  localparam string VREQ [NV] = '{"R2", "R3", "R5", "R6", "R6", "R5", "R1", "R2", "R4",
                                  "R5", "R5", "R1", "R1", "R3", "R7", "R7", "R7", "R4"};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [CW-1:0] code_i = CW'(2500);
  logic [1:0]    state_o;
  logic          chg_o;

  int n_run = 0, n_fail = 0;
  int mon_err = 0, n_strobe = 0;
  logic [1:0] prev_st = 2'b10;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  pwm3_decoder #(.CODE_W(CW), .HOLD_CYCLES(HOLD)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(code_i), .state_o(state_o), .chg_o(chg_o)
  );

  // R9 R10 monitor on ports
  always @(negedge clk_i) begin
    if (!rst_ni) prev_st <= 2'b10;
    else begin
      if (chg_o !== (state_o != prev_st)) mon_err++;
      if (state_o === 2'b11) mon_err++;
      if (chg_o) n_strobe++;
      prev_st <= state_o;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R8 during reset
    check("R8", int'(state_o), 2);
    check("R8", int'(chg_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8", int'(state_o), 2);
    check("R8", int'(chg_o), 0);

    for (int i = 0; i < NV; i++) begin
      code_i = CW'(VCODE[i]);
      repeat (VCYC[i]) @(posedge clk_i);
      @(negedge clk_i);
      check(VREQ[i], int'(state_o), VEXP[i]);
    end

    // R9 strobe behaviour and count over the table
    check("R9", mon_err, 0);
    check("R9", n_strobe, 8);

    // R8 reset in mid-run while LOW
    rst_ni = 1'b0;
    #1;
    check("R8", int'(state_o), 2);
    check("R8", int'(chg_o), 0);
    code_i = CW'(2500);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 open pin at mid-supply keeps shutdown, no strobe
    n_strobe = 0;
    repeat (40) @(negedge clk_i);
    check("R1", int'(state_o), 2);
    check("R1", n_strobe, 0);

    // R2 leaving shutdown strobes once on the first sampling edge
    code_i = CW'(3551);
    @(posedge clk_i);
    @(negedge clk_i);
    check("R2", int'(state_o), 1);
    check("R9", int'(chg_o), 1);
    @(negedge clk_i);
    check("R9", int'(chg_o), 0);

    // R5 exact dwell: HOLD-1 samples keep HIGH, the HOLD-th gives shutdown
    code_i = CW'(2000);
    repeat (HOLD - 1) @(posedge clk_i);
    @(negedge clk_i);
    check("R5", int'(state_o), 1);
    @(posedge clk_i);
    @(negedge clk_i);
    check("R5", int'(state_o), 2);
    check("R9", mon_err, 0);

    finish_run();
  end
endmodule